// File: doc/BRIEF.md
# Output Drive Impedance Calibration Sequencer

This block keeps two binary-weighted drive-strength codes, one for the pull-down leg and one for the pull-up leg of an output pad, tracking an external impedance reference. The comparison itself is done outside the block. For each leg, a comparator bit tells the block whether that leg is currently too strong or too weak. A free-running interval timer fires an evaluation at a fixed spacing. At each evaluation, each leg computes a candidate code exactly one step from the code it is using, moving toward the reference.

A candidate code is not pushed onto a leg while that leg is driving the pad, because switching it then would disturb the level being driven. The candidate waits in a shadow register. It is applied on the first clock edge at which the leg is idle. The pull-down leg is idle when the pad drives a one or is high-impedance. The pull-up leg is idle when the pad drives a zero or is high-impedance. If the next evaluation arrives while a candidate is still waiting, the new candidate replaces it. A separate start-up tracker counts clock cycles from reset, whatever the pad is doing, and raises a ready flag once the start-up window has elapsed.

Each leg runs a two-state machine. In LEG_SETTLED nothing is waiting. An evaluation whose candidate differs from the applied code moves the leg to LEG_ARMED. In LEG_ARMED a candidate is waiting. An idle edge with no evaluation applies the candidate and returns the leg to LEG_SETTLED. An evaluation that lands in LEG_ARMED either reloads the shadow and stays in LEG_ARMED, or, when the new candidate equals the applied code, drops the wait and returns to LEG_SETTLED. The start-up tracker has two states, SU_WARMUP and SU_DONE. It leaves SU_WARMUP on the edge that completes the window and never returns until reset.

Top module: `zq_cal_sequencer`

## Requirements
- R1: While reset is asserted, and directly after it, both codes equal mid-scale (2^(CODE_W-1), which is 32 for 6-bit codes) and `cal_ready` is 0.
- R2: Evaluations happen only on rising edges whose count since reset release is a nonzero multiple of EVAL_PERIOD (at least 2). The comparator bits are sampled on those edges only. An evaluation edge never changes a code itself: the earliest change comes one edge later, and no code changes at any other time.
- R3: At an evaluation, a comparator bit of 1 (leg too strong) yields a candidate equal to the applied code minus one. A bit of 0 (leg too weak) yields the applied code plus one.
- R4: Codes saturate: a leg at all-ones that is too weak, or at all-zeros that is too strong, keeps its code, and no code ever wraps around.
- R5: A pull-down candidate is applied on the first rising edge after its evaluation at which `pad_oe` is 0 or `pad_val` is 1. It is held while the pad drives a zero.
- R6: A pull-up candidate is applied on the first rising edge after its evaluation at which `pad_oe` is 0 or `pad_val` is 0. It is held while the pad drives a one.
- R7: A later evaluation replaces a waiting candidate. The replacement is computed from the applied code, so however many evaluations pass while a leg is busy, the leg moves by at most one step when it becomes idle, and in the direction of the latest evaluation.
- R8: `cal_ready` rises on the rising edge that completes STARTUP_CYCLES edges since reset release (32768 by default), independent of pad activity, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_oe | input | 1 | 1 when the pad is driven, 0 when it is high-impedance |
| pad_val | input | 1 | Level driven on the pad when `pad_oe` is 1 |
| pd_too_strong | input | 1 | Comparator: 1 = pull-down leg too strong, 0 = too weak |
| pu_too_strong | input | 1 | Comparator: 1 = pull-up leg too strong, 0 = too weak |
| pd_code | output | CODE_W | Applied pull-down drive code |
| pu_code | output | CODE_W | Applied pull-up drive code |
| cal_ready | output | 1 | Start-up window has elapsed |

## Verification
The assertions assume that reset is held for at least one rising edge before release, that EVAL_PERIOD is 2 or more, and that the pad and comparator inputs are stable at every rising edge. The bench meets these assumptions by changing every input only on falling edges and by releasing reset after several clock cycles. The bench runs a short evaluation period of 16 cycles, so many evaluations, both saturation limits and every pad state fit well inside the default start-up window. It counts edges since reset release and predicts each code arithmetically at the edge that follows each evaluation.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;

    typedef enum logic {
        LEG_SETTLED = 1'b0,
        LEG_ARMED   = 1'b1
    } leg_state_e;

    typedef enum logic {
        SU_WARMUP = 1'b0,
        SU_DONE   = 1'b1
    } startup_state_e;

    localparam int unsigned NUM_LEGS = 2;
    localparam int unsigned LEG_PD   = 0;
    localparam int unsigned LEG_PU   = 1;

endpackage

// File: rtl/zq_eval_timer.sv
module zq_eval_timer #(
    parameter int unsigned EVAL_PERIOD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic eval_tick
);

    localparam int unsigned CNT_W = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(EVAL_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST_CNT) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        eval_tick = (cnt_q == LAST_CNT);
    end

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eval_tick |=> !eval_tick); // R2

endmodule

// File: rtl/zq_startup_tracker.sv
module zq_startup_tracker
    import zq_cal_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);

    localparam int unsigned SU_W = $clog2(STARTUP_CYCLES + 1);
    localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_CYCLES - 1);

    startup_state_e   state_q, state_d;
    logic [SU_W-1:0]  cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SU_WARMUP: if (cnt_q == SU_LAST) state_d = SU_DONE;
            SU_DONE:   state_d = SU_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SU_WARMUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == SU_WARMUP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ready = (state_q == SU_DONE);
    end

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R8

endmodule

// File: rtl/zq_leg_stepper.sv
module zq_leg_stepper
    import zq_cal_pkg::*;
#(
    parameter int unsigned CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_tick,
    input  logic              too_strong,
    input  logic              leg_idle,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    leg_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] shadow_q;
    logic [CODE_W-1:0] step_code;
    logic              moves;

    always_comb begin
        if (too_strong) begin
            step_code = (code_q == '0) ? code_q : code_q - 1'b1;
        end else begin
            step_code = (code_q == MAX_CODE) ? code_q : code_q + 1'b1;
        end
        moves = (step_code != code_q);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_SETTLED: begin
                if (eval_tick && moves) state_d = LEG_ARMED;
            end
            LEG_ARMED: begin
                if (eval_tick) begin
                    state_d = moves ? LEG_ARMED : LEG_SETTLED;
                end else if (leg_idle) begin
                    state_d = LEG_SETTLED;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LEG_SETTLED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= MID_CODE;
            code_q   <= MID_CODE;
        end else begin
            if (eval_tick && moves) begin
                shadow_q <= step_code;
            end
            if ((state_q == LEG_ARMED) && !eval_tick && leg_idle) begin
                code_q <= shadow_q;
            end
        end
    end

    always_comb begin
        code = code_q;
    end

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |->
            ((code_q == $past(code_q) + CODE_W'(1)) ||
             (code_q == $past(code_q) - CODE_W'(1)))); // R3

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_q) == MAX_CODE) |-> (code_q != '0)); // R4

    AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_q) == '0) |-> (code_q != MAX_CODE)); // R4

    AST_NOT_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |-> !$past(eval_tick)); // R2

endmodule

// File: rtl/zq_cal_sequencer.sv
module zq_cal_sequencer
    import zq_cal_pkg::*;
#(
    parameter int unsigned CODE_W         = 6,
    parameter int unsigned EVAL_PERIOD    = 1024,
    parameter int unsigned STARTUP_CYCLES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_oe,
    input  logic              pad_val,
    input  logic              pd_too_strong,
    input  logic              pu_too_strong,
    output logic [CODE_W-1:0] pd_code,
    output logic [CODE_W-1:0] pu_code,
    output logic              cal_ready
);

    logic                eval_tick;
    logic [NUM_LEGS-1:0] leg_idle;
    logic [NUM_LEGS-1:0] leg_strong;
    logic [CODE_W-1:0]   leg_code [NUM_LEGS];

    always_comb begin
        leg_idle[LEG_PD]   = !pad_oe || pad_val;
        leg_idle[LEG_PU]   = !pad_oe || !pad_val;
        leg_strong[LEG_PD] = pd_too_strong;
        leg_strong[LEG_PU] = pu_too_strong;
    end

    zq_eval_timer #(
        .EVAL_PERIOD (EVAL_PERIOD)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_tick (eval_tick)
    );

    zq_startup_tracker #(
        .STARTUP_CYCLES (STARTUP_CYCLES)
    ) u_startup (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (cal_ready)
    );

    for (genvar gi = 0; gi < NUM_LEGS; gi++) begin : g_leg
        zq_leg_stepper #(
            .CODE_W (CODE_W)
        ) u_leg (
            .clk        (clk),
            .rst_n      (rst_n),
            .eval_tick  (eval_tick),
            .too_strong (leg_strong[gi]),
            .leg_idle   (leg_idle[gi]),
            .code       (leg_code[gi])
        );
    end

    always_comb begin
        pd_code = leg_code[LEG_PD];
        pu_code = leg_code[LEG_PU];
    end

    AST_PD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_code != $past(pd_code)) |-> $past(!pad_oe || pad_val)); // R5

    AST_PU_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_code != $past(pu_code)) |-> $past(!pad_oe || !pad_val)); // R6

endmodule

// File: tb/zq_cal_sequencer_tb_top.sv
module zq_cal_sequencer_tb_top;

    localparam int unsigned CW  = 6;
    localparam int unsigned P   = 16;
    localparam int unsigned SU  = 32768;
    localparam int          MAXC = (1 << CW) - 1;
    localparam int          MIDC = 1 << (CW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pad_oe = 1'b1;
    logic          pad_val = 1'b1;
    logic          pd_too_strong = 1'b0;
    logic          pu_too_strong = 1'b1;
    logic [CW-1:0] pd_code;
    logic [CW-1:0] pu_code;
    logic          cal_ready;

    int edge_n = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    zq_cal_sequencer #(
        .CODE_W         (CW),
        .EVAL_PERIOD    (P),
        .STARTUP_CYCLES (SU)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pad_oe        (pad_oe),
        .pad_val       (pad_val),
        .pd_too_strong (pd_too_strong),
        .pu_too_strong (pu_too_strong),
        .pd_code       (pd_code),
        .pu_code       (pu_code),
        .cal_ready     (cal_ready)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", req, what, act, exp, edge_n);
        end
    endtask

    task automatic wait_edge(input int n);
        while (edge_n < n) @(negedge clk);
    endtask

    function automatic int sat(input int v);
        if (v < 0) return 0;
        if (v > MAXC) return MAXC;
        return v;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(64'd200000 * 64'd20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values held in reset
        check("R1", "pd_code in reset", pd_code, MIDC);
        check("R1", "pu_code in reset", pu_code, MIDC);
        check("R1", "cal_ready in reset", cal_ready, 0);
        rst_n = 1'b1;

        // R2: first evaluation at edge P loads only the shadow
        wait_edge(P - 1);
        check("R2", "pd before first eval", pd_code, MIDC);
        wait_edge(P);
        check("R2", "pd on eval edge", pd_code, MIDC);

        // R3 R4 R5 R6: pad drives one, pull-down idle and rising, pull-up busy
        for (int k = 1; k <= 40; k++) begin
            wait_edge(k * P + 1);
            check("R3", "pd step up", pd_code, sat(MIDC + k));
            check("R6", "pu held while pad drives one", pu_code, MIDC);
        end
        check("R4", "pd saturated at max", pd_code, MAXC);

        // R7: forty waiting evaluations collapse to one step
        pad_oe = 1'b0;
        pd_too_strong = 1'b1;
        wait_edge(40 * P + 2);
        check("R7", "pu single step after long wait", pu_code, MIDC - 1);
        check("R4", "pd stays at max", pd_code, MAXC);

        // R3 R4: high-impedance, both legs too strong
        for (int j = 1; j <= 40; j++) begin
            wait_edge((40 + j) * P + 1);
            check("R3", "pd step down", pd_code, sat(MAXC - j));
            check("R4", "pu step down to floor", pu_code, sat(MIDC - 1 - j));
        end

        // R5 R6: pad drives zero, pull-up idle, pull-down busy
        pad_oe = 1'b1;
        pad_val = 1'b0;
        pd_too_strong = 1'b0;
        pu_too_strong = 1'b0;
        for (int j = 1; j <= 4; j++) begin
            wait_edge((80 + j) * P + 1);
            check("R6", "pu step up while pad drives zero", pu_code, j);
            check("R5", "pd held while pad drives zero", pd_code, MAXC - 40);
        end
        pad_val = 1'b1;
        wait_edge(84 * P + 2);
        check("R5", "pd applied when pad drives one", pd_code, MAXC - 39);
        check("R6", "pu unchanged", pu_code, 4);
        wait_edge(85 * P + 1);
        check("R5", "pd next step", pd_code, MAXC - 38);
        check("R6", "pu held while pad drives one", pu_code, 4);

        // R7: direction reversal replaces the waiting candidate
        pu_too_strong = 1'b1;
        wait_edge(86 * P + 1);
        check("R5", "pd step", pd_code, MAXC - 37);
        check("R7", "pu still held", pu_code, 4);
        pad_oe = 1'b0;
        wait_edge(86 * P + 2);
        check("R7", "pu takes replaced candidate", pu_code, 3);
        wait_edge(86 * P + 8);
        check("R2", "pd stable between evaluations", pd_code, MAXC - 37);
        wait_edge(87 * P - 1);
        check("R2", "pd stable before next eval", pd_code, MAXC - 37);
        wait_edge(87 * P + 1);
        check("R3", "pd after eval", pd_code, MAXC - 36);
        check("R3", "pu after eval", pu_code, 2);

        // R8: start-up window
        wait_edge(SU - 1);
        check("R8", "ready one edge early", cal_ready, 0);
        wait_edge(SU);
        check("R8", "ready at window end", cal_ready, 1);
        pad_oe = 1'b1;
        wait_edge(SU + 3 * P);
        check("R8", "ready stays high", cal_ready, 1);

        // R1: reset again
        rst_n = 1'b0;
        #1;
        check("R1", "pd after re-reset", pd_code, MIDC);
        check("R1", "pu after re-reset", pu_code, MIDC);
        check("R1", "ready after re-reset", cal_ready, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule